// File: doc/BRIEF.md
# Ramp Pulse-Width Calibrator

This block finds the pulse width at which an integrated positive ramp just reaches a reference voltage. It uses a binary search that advances one step per invocation. The search window is a pair of 16-bit bounds held in registers. Each `start` looks at that window and does exactly one of three things:

- It reopens the window if the window is inconsistent.
- It publishes a result if the window has closed to a single value.
- Otherwise it requests one trial pulse at the window midpoint from the external pulse sequencer, waits for the comparator verdict, and halves the window.

Converged widths are not used directly. Each one is fed into a first-order exponential smoother, and the smoother's output is the scale factor that later conversions use. A higher-level scheduler calls the block repeatedly and watches `done` and `complete`. The analog circuitry and the pulse timing both sit outside the block.

Top module: `ramp_tune_cal`

## Requirements
- R1: After reset the outputs are quiet: `trialReq`, `done` and `complete` are 0, `scaleOut` is 0 and `firstTuneDone` is 0.
- R2: Reset leaves the window inconsistent (upper bound 0, lower bound 65535). A `start` on an inconsistent window (upper below lower) sets the window to upper 65535, lower 0. It raises `done` for one cycle with `complete` at 0 and issues no trial.
- R3: A `start` on a window whose bounds differ raises `trialReq` in the next cycle. `trialWidth` then equals floor((upper+lower)/2), computed without overflow even for 65535+65534.
- R4: `trialReq` and `trialWidth` hold steady until `cmpValid` is sampled high. In the cycle after that, `trialReq` is 0 and `done` is 1, for exactly one cycle.
- R5: When the trial completes with `cmpAbove`=1 (ramp above reference), the upper bound becomes the midpoint. With `cmpAbove`=0, the lower bound becomes the midpoint, except that when upper−lower is 1 the lower bound becomes the upper bound.
- R6: A `start` on a closed window (upper equals lower) pushes that value into the smoother. It raises `done` and `complete` together for one cycle, issues no trial, and reopens the window to 0..65535.
- R7: The first push loads `scaleOut` with the pushed value. Each later push applies scaleOut += (x − scaleOut) >>> FILT_SHIFT as a signed arithmetic shift, with FILT_SHIFT defaulting to 2.
- R8: `firstTuneDone` rises with the first push and stays 1 until reset.
- R9: `start` has no effect while a trial is outstanding. `cmpValid` has no effect while no trial is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Run one calibration step |
| trialReq | output | 1 | Trial pulse requested |
| trialWidth | output | 16 | Width of the requested trial pulse |
| cmpValid | input | 1 | Comparator verdict is present |
| cmpAbove | input | 1 | 1 = ramp ended above reference |
| done | output | 1 | One-cycle end-of-step strobe |
| complete | output | 1 | One-cycle strobe: a converged value was pushed |
| scaleOut | output | 16 | Smoothed scale factor |
| firstTuneDone | output | 1 | At least one push since reset |

## Verification
Several properties are checked on every cycle:
- The request is held while the comparator is silent.
- `start` cannot disturb an outstanding trial.
- `complete` never appears without `done`.
- Every bisection leaves the window consistent and strictly narrower.
- The first-push flag never falls.

Other behaviour can only be shown by the bench's scenarios, which compare against an independent model across directed and random targets. This covers the exact midpoint values, including the 17-bit sum at the top of the range, and the values the search converges to at targets 0 and 65535. It also covers the smoothed scale after successive searches and the absence of effect from stray comparator strobes.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_TRIAL = 1'b1} rtcStateT;

  typedef struct packed {
    logic reopen;   // set window to full range
    logic push;     // send converged value to smoother
    logic stepUp;   // upper bound := midpoint
    logic stepDn;   // lower bound := midpoint (or upper when adjacent)
  } rtcStrobeT;
endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      cmpValid,
  input  logic      cmpAbove,
  input  logic      winInvalid,
  input  logic      winClosed,
  output rtcStrobeT strb,
  output logic      trialReq,
  output logic      done,
  output logic      complete
);
  rtcStateT stateQ;
  logic idleStart, trialEnd;

  assign idleStart = (stateQ == ST_IDLE) && start;
  assign trialEnd  = (stateQ == ST_TRIAL) && cmpValid;

  always_comb begin
    strb        = '0;
    strb.reopen = idleStart && winInvalid;
    strb.push   = idleStart && !winInvalid && winClosed;
    strb.stepUp = trialEnd && cmpAbove;
    strb.stepDn = trialEnd && !cmpAbove;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      done     <= 1'b0;
      complete <= 1'b0;
    end else begin
      done     <= (idleStart && (winInvalid || winClosed)) || trialEnd;
      complete <= idleStart && !winInvalid && winClosed;
      if (idleStart && !winInvalid && !winClosed) stateQ <= ST_TRIAL;
      else if (trialEnd)                          stateQ <= ST_IDLE;
    end
  end

  assign trialReq = (stateQ == ST_TRIAL);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trialReq && !cmpValid) |=> trialReq);

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (trialReq && start && !cmpValid) |=> (trialReq && !done));

  // R6
  complete_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    complete |-> done);

  // R4
  no_req_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && trialReq));
endmodule

// File: rtl/rtc_window.sv
module rtc_window
  import rtc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  rtcStrobeT    strb,
  output logic         winInvalid,
  output logic         winClosed,
  output logic [W-1:0] midW,
  output logic [W-1:0] closedVal
);
  localparam logic [W-1:0] FULL = {W{1'b1}};
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] upQ, loQ;
  logic [W:0]   sumW;

  assign sumW       = {1'b0, upQ} + {1'b0, loQ};
  assign midW       = W'(sumW >> 1);
  assign winInvalid = upQ < loQ;
  assign winClosed  = upQ == loQ;
  assign closedVal  = upQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      upQ <= '0;
      loQ <= FULL;
    end else if (strb.reopen || strb.push) begin
      upQ <= FULL;
      loQ <= '0;
    end else if (strb.stepUp) begin
      upQ <= midW;
    end else if (strb.stepDn) begin
      if ((upQ - loQ) == ONE) loQ <= upQ;
      else                    loQ <= midW;
    end
  end

  // R5
  step_consistent_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp || strb.stepDn) |=> (upQ >= loQ));

  // R5
  step_narrows_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.stepUp || strb.stepDn) |=> ((upQ - loQ) < $past(upQ - loQ)));

  // R2
  reopen_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.reopen |=> (upQ == FULL && loQ == '0));
endmodule

// File: rtl/rtc_filter.sv
module rtc_filter #(
  parameter int W     = 16,
  parameter int SHIFT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] sample,
  output logic [W-1:0] yOut,
  output logic         primed
);
  logic signed [W:0] diffS;
  logic        [W-1:0] stepW;

  assign diffS = $signed({1'b0, sample}) - $signed({1'b0, yOut});
  assign stepW = W'(diffS >>> SHIFT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      yOut   <= '0;
      primed <= 1'b0;
    end else if (push) begin
      primed <= 1'b1;
      if (!primed) yOut <= sample;
      else         yOut <= yOut + stepW;
    end
  end

  // R8
  primed_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    push |=> primed);

  // R8
  primed_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed |=> primed);

  // R7
  first_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && !primed) |=> (yOut == $past(sample)));
endmodule

// File: rtl/ramp_tune_cal.sv
module ramp_tune_cal
  import rtc_pkg::*;
#(
  parameter int W          = 16,
  parameter int FILT_SHIFT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output logic         trialReq,
  output logic [W-1:0] trialWidth,
  input  logic         cmpValid,
  input  logic         cmpAbove,
  output logic         done,
  output logic         complete,
  output logic [W-1:0] scaleOut,
  output logic         firstTuneDone
);
  rtcStrobeT    strb;
  logic         winInvalid, winClosed;
  logic [W-1:0] closedVal;

  rtc_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmpValid(cmpValid),
    .cmpAbove(cmpAbove), .winInvalid(winInvalid), .winClosed(winClosed),
    .strb(strb), .trialReq(trialReq), .done(done), .complete(complete)
  );

  rtc_window #(.W(W)) u_window (
    .clk(clk), .rstN(rstN), .strb(strb), .winInvalid(winInvalid),
    .winClosed(winClosed), .midW(trialWidth), .closedVal(closedVal)
  );

  rtc_filter #(.W(W), .SHIFT(FILT_SHIFT)) u_filter (
    .clk(clk), .rstN(rstN), .push(strb.push), .sample(closedVal),
    .yOut(scaleOut), .primed(firstTuneDone)
  );
endmodule

// File: tb/ramp_tune_cal_tb.sv
module ramp_tune_cal_tb;
  localparam int CLK_PERIOD = 10;
  localparam int K = 2;

  logic clk = 0, rstN = 0, start = 0, cmpValid = 0, cmpAbove = 0;
  logic trialReq, done, complete, firstTuneDone;
  logic [15:0] trialWidth, scaleOut;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  logic [15:0] mUp = 16'h0000, mLo = 16'hFFFF, mY = 0;
  bit mFirst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_tune_cal #(.W(16), .FILT_SHIFT(K)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .trialReq(trialReq),
    .trialWidth(trialWidth), .cmpValid(cmpValid), .cmpAbove(cmpAbove),
    .done(done), .complete(complete), .scaleOut(scaleOut),
    .firstTuneDone(firstTuneDone)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] smooth(input logic [15:0] y, input logic [15:0] x);
    int d;
    d = int'(x) - int'(y);
    d = d >>> K;
    return 16'(int'(y) + d);
  endfunction

  // One invocation; returns 1 when a push (complete) happened.
  task automatic invoke(input logic [15:0] target, input int waitCyc,
                        input bit pokeStart, output bit pushed);
    logic [16:0] sum;
    logic [15:0] mid;
    bit above;
    pushed = 0;
    @(negedge clk);
    chk(done == 0, "R4 done single cycle", done, 0);
    start = 1;
    @(negedge clk);
    start = 0;
    if (mUp < mLo) begin
      mUp = 16'hFFFF; mLo = 0;
      chk(done && !complete && !trialReq, "R2 reopen done only", {done, complete, trialReq}, 3'b100);
    end else if (mUp == mLo) begin
      mY = mFirst ? smooth(mY, mUp) : mUp;
      mFirst = 1;
      mUp = 16'hFFFF; mLo = 0;
      pushed = 1;
      chk(done && complete && !trialReq, "R6 push strobes", {done, complete, trialReq}, 3'b110);
      chk(scaleOut == mY, "R7 scale", scaleOut, mY);
      chk(firstTuneDone == 1, "R8 flag", firstTuneDone, 1);
    end else begin
      sum = {1'b0, mUp} + {1'b0, mLo};
      mid = sum[16:1];
      chk(trialReq && !done, "R3 trial raised", {trialReq, done}, 2'b10);
      chk(trialWidth == mid, "R3 width", trialWidth, mid);
      for (int i = 0; i < waitCyc; i++) begin
        start = pokeStart;
        @(negedge clk);
        start = 0;
        chk(trialReq && trialWidth == mid && !done, "R4 R9 hold", trialWidth, mid);
      end
      above = (mid >= target);
      cmpValid = 1; cmpAbove = above;
      @(negedge clk);
      cmpValid = 0; cmpAbove = 0;
      chk(done && !trialReq && !complete, "R4 trial end", {done, trialReq, complete}, 3'b100);
      if (above) mUp = mid;
      else if (mUp - mLo == 16'd1) mLo = mUp;
      else mLo = mid;
    end
  endtask

  task automatic stray_cmp();
    @(negedge clk);
    cmpValid = 1; cmpAbove = 1'($urandom);
    @(negedge clk);
    cmpValid = 0;
    chk(!done && !trialReq, "R9 idle cmpValid ignored", {done, trialReq}, 0);
  endtask

  task automatic search(input logic [15:0] target, input bit noisy);
    bit pushed;
    int n = 0;
    pushed = 0;
    while (!pushed && n < 40) begin
      if (noisy && ($urandom % 4 == 0)) stray_cmp();
      invoke(target, noisy ? int'($urandom % 3) : 0, noisy, pushed);
      n++;
    end
    chk(pushed, "R5 search converges", n, 40);
  endtask

  initial begin
    void'($urandom(32'h5EED1234));
    repeat (3) @(negedge clk);
    chk(!trialReq && !done && !complete, "R1 quiet", {trialReq, done, complete}, 0);
    chk(scaleOut == 0 && !firstTuneDone, "R1 scale/flag", scaleOut, 0);
    rstN = 1;
    // R2: first start reopens the invalid window
    begin bit p; invoke(16'd100, 0, 0, p); end
    chk(firstTuneDone == 0, "R8 not yet set", firstTuneDone, 0);
    // R5 boundaries: target 65535 exercises 17-bit midpoint (R3) and adjacency rule
    search(16'hFFFF, 0);
    chk(scaleOut == 16'hFFFF, "R7 first load", scaleOut, 16'hFFFF);
    search(16'h0000, 0);
    search(16'h0001, 1);
    for (int s = 0; s < 6; s++) search(16'($urandom), 1);
    chk(firstTuneDone == 1, "R8 sticky", firstTuneDone, 1);
    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule